// File: doc/BRIEF.md
# Store-Miss Line Allocation Controller

This block sits beside a data cache and decides what a store does to the cache and to external memory. A store that hits is handled in the cycle it is accepted. In a write-back region it writes only the cache array and marks the touched half-line dirty. In a write-through region it writes the cache and also pushes the store to the write buffer, and it leaves the dirty bits clear. A store that misses with allocation disabled becomes one external write of exactly the store's bytes.

A store that misses with allocation enabled is parked in a one-entry fill buffer, and a 32-byte line read is issued. The eight returned words may arrive in any order. Once the line is complete, the victim line (supplied by separate replacement logic) is evicted. Each dirty four-word half of a valid victim goes to the write buffer as its own burst. Then the fetched line is written into the array with the parked store's bytes overlaid on it. While the fill buffer is occupied, further stores are held off.

Top module: `wmiss_alloc_ctrl`

## Requirements
- R1: A write-back store hit is accepted in the same cycle. It drives a partial cache write whose byte enables cover only the store's bytes at word offset addr[4:2]. It sets dirty bit 0 when addr[4] is 0 and dirty bit 1 when addr[4] is 1, and it pushes nothing to the write buffer.
- R2: A write-through store hit, in its acceptance cycle, drives the same partial cache write with both dirty bits clear. It also pushes a single, non-burst write carrying the store data.
- R3: A miss with allocation off pushes one non-burst write in its acceptance cycle. The push carries the word-aligned address, the store data in bits 31:0 and the store's byte enables. There is no cache write and no line read.
- R4: A miss with allocation on raises the line read for exactly one cycle, the cycle after acceptance. The read address is the store address with bits 4:0 cleared.
- R5: Returned words are placed by their 3-bit word offset in whatever order they arrive. The line is not written to the cache before all eight offsets have been received.
- R6: After the eighth word, a valid victim pushes each half whose dirty bit is set as a burst: the lower half (words 0-3, byte offset 0) first, then the upper half (words 4-7, byte offset 16). Each burst carries all byte enables. Clean halves and invalid victims push nothing.
- R7: A push never happens while the write buffer reports full. Eviction waits in place, and stores that would push are not accepted until room appears.
- R8: The install writes the whole line with the store's enabled bytes replacing the fetched bytes of its word. It sets the touched half's dirty bit in write-back regions and no dirty bit in write-through regions. A write-through allocating miss also pushes its single write at acceptance.
- R9: Store ready is low from the cycle after an allocating miss is accepted until the install cycle has passed.
- R10: After reset, store ready is high and no read, push or cache write is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store request valid |
| st_ready_o | output | 1 | Store accepted when high with valid |
| st_addr_i | input | AW | Store byte address |
| st_data_i | input | DW | Store data |
| st_be_i | input | DW/8 | Store byte enables |
| st_hit_i | input | 1 | Store hits the cache |
| st_wt_i | input | 1 | Region is write-through |
| st_alloc_i | input | 1 | Line allocation permitted on miss |
| rd_req_o | output | 1 | Line read request |
| rd_addr_o | output | AW | Line-aligned read address |
| rv_valid_i | input | 1 | Returned word valid |
| rv_off_i | input | log2(WORDS) | Word offset of returned word |
| rv_data_i | input | DW | Returned word data |
| vic_valid_i | input | 1 | Victim line holds valid data |
| vic_dirty_i | input | 2 | Victim dirty bits, bit 0 lower half |
| vic_line_i | input | AW-5 | Victim line address |
| vic_data_i | input | WORDS*DW | Victim line contents |
| wb_push_o | output | 1 | Write-buffer push |
| wb_full_i | input | 1 | Write buffer has no room |
| wb_burst_o | output | 1 | Push is a four-word burst |
| wb_addr_o | output | AW | Push byte address |
| wb_data_o | output | WORDS/2*DW | Push data, word 0 in low bits |
| wb_be_o | output | DW/8 | Byte enables of a single push |
| cw_en_o | output | 1 | Cache array write |
| cw_fill_o | output | 1 | Write is a full-line install |
| cw_line_o | output | AW-5 | Line address written |
| cw_data_o | output | WORDS*DW | Line-wide write data |
| cw_be_o | output | WORDS*DW/8 | Line-wide byte enables |
| cw_dirty_o | output | 2 | Dirty bits to set |

## Verification
Hit and no-allocate results are combinational on the accepted request, so the bench drives a store shortly after a rising edge and samples all outputs mid-cycle, before the next edge. The line read is due one edge after acceptance. The first eviction push is due one edge after the eighth returned word, the upper-half push one edge after that, and the install one edge after the upper-half slot. The bench steps one edge at a time through that window and checks pushes and the install in the exact cycles where they fall. It holds the write buffer full for a fixed number of cycles and checks that nothing moves.

// File: rtl/wmiss_pkg.sv
package wmiss_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_REQ, S_FILL, S_EV_LO, S_EV_HI, S_INST
  } wm_state_e;
endpackage

// File: rtl/wmiss_fill_buf.sv
module wmiss_fill_buf #(
  parameter int WORDS = 8,
  parameter int DW    = 32,
  localparam int OW   = $clog2(WORDS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                beat_i,
  input  logic [OW-1:0]       off_i,
  input  logic [DW-1:0]       data_i,
  output logic                done_o,
  output logic [WORDS*DW-1:0] line_o
);
  logic [WORDS-1:0] rcvd_q;
  logic [WORDS-1:0] beat_dec;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign beat_dec[w] = beat_i && (off_i == OW'(w));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rcvd_q[w]          <= 1'b0;
        line_o[w*DW +: DW] <= '0;
      end else if (clr_i) begin
        rcvd_q[w] <= 1'b0;
      end else if (beat_dec[w]) begin
        rcvd_q[w]          <= 1'b1;
        line_o[w*DW +: DW] <= data_i;
      end
    end
  end

  // complete once this beat fills the last hole
  assign done_o = &(rcvd_q | beat_dec);
endmodule

// File: rtl/wmiss_merge.sv
module wmiss_merge #(
  parameter int WORDS = 8,
  parameter int DW    = 32,
  localparam int OW   = $clog2(WORDS),
  localparam int BB   = DW / 8
) (
  input  logic [WORDS*DW-1:0] line_i,
  input  logic [OW-1:0]       off_i,
  input  logic [DW-1:0]       data_i,
  input  logic [BB-1:0]       be_i,
  output logic [WORDS*DW-1:0] line_o
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    for (genvar b = 0; b < BB; b++) begin : g_byte
      assign line_o[w*DW + b*8 +: 8] = (off_i == OW'(w) && be_i[b]) ?
                                       data_i[b*8 +: 8] : line_i[w*DW + b*8 +: 8];
    end
  end
endmodule

// File: rtl/wmiss_half_sel.sv
module wmiss_half_sel #(
  parameter int WORDS = 8,
  parameter int DW    = 32,
  localparam int HDW  = WORDS / 2 * DW
) (
  input  logic                half_i,
  input  logic [WORDS*DW-1:0] line_i,
  output logic [HDW-1:0]      data_o
);
  assign data_o = half_i ? line_i[HDW +: HDW] : line_i[0 +: HDW];
endmodule

// File: rtl/wmiss_alloc_ctrl.sv
module wmiss_alloc_ctrl
  import wmiss_pkg::*;
#(
  parameter int AW    = 32,
  parameter int WORDS = 8,
  parameter int DW    = 32,
  localparam int OW   = $clog2(WORDS),
  localparam int BB   = DW / 8,
  localparam int BOB  = $clog2(BB),
  localparam int OFFB = OW + BOB,
  localparam int LAW  = AW - OFFB,
  localparam int LW   = WORDS * DW,
  localparam int LB   = LW / 8,
  localparam int HDW  = WORDS / 2 * DW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            st_valid_i,
  output logic            st_ready_o,
  input  logic [AW-1:0]   st_addr_i,
  input  logic [DW-1:0]   st_data_i,
  input  logic [BB-1:0]   st_be_i,
  input  logic            st_hit_i,
  input  logic            st_wt_i,
  input  logic            st_alloc_i,
  output logic            rd_req_o,
  output logic [AW-1:0]   rd_addr_o,
  input  logic            rv_valid_i,
  input  logic [OW-1:0]   rv_off_i,
  input  logic [DW-1:0]   rv_data_i,
  input  logic            vic_valid_i,
  input  logic [1:0]      vic_dirty_i,
  input  logic [LAW-1:0]  vic_line_i,
  input  logic [LW-1:0]   vic_data_i,
  output logic            wb_push_o,
  input  logic            wb_full_i,
  output logic            wb_burst_o,
  output logic [AW-1:0]   wb_addr_o,
  output logic [HDW-1:0]  wb_data_o,
  output logic [BB-1:0]   wb_be_o,
  output logic            cw_en_o,
  output logic            cw_fill_o,
  output logic [LAW-1:0]  cw_line_o,
  output logic [LW-1:0]   cw_data_o,
  output logic [LB-1:0]   cw_be_o,
  output logic [1:0]      cw_dirty_o
);
  wm_state_e state_q, state_d;

  logic [AW-1:0] fb_addr_q;
  logic [DW-1:0] fb_data_q;
  logic [BB-1:0] fb_be_q;
  logic          fb_wt_q;

  logic          idle, needs_push, acc, acc_alloc;
  logic [OW-1:0] st_off, fb_off;
  logic          fill_beat, fill_done;
  logic [LW-1:0] fill_line, inst_line;
  logic          in_ev, ev_half, ev_need;
  logic [HDW-1:0] ev_data;

  assign idle       = (state_q == S_IDLE);
  assign needs_push = st_wt_i | (~st_hit_i & ~st_alloc_i);
  assign st_ready_o = idle & ~(needs_push & wb_full_i);
  assign acc        = st_valid_i & st_ready_o;
  assign acc_alloc  = acc & ~st_hit_i & st_alloc_i;
  assign st_off     = st_addr_i[OFFB-1:BOB];
  assign fb_off     = fb_addr_q[OFFB-1:BOB];

  assign fill_beat = rv_valid_i & (state_q == S_FILL);
  assign in_ev     = (state_q == S_EV_LO) | (state_q == S_EV_HI);
  assign ev_half   = (state_q == S_EV_HI);
  assign ev_need   = vic_valid_i & vic_dirty_i[ev_half];

  wmiss_fill_buf #(.WORDS(WORDS), .DW(DW)) fill_buf_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (acc_alloc),
    .beat_i (fill_beat),
    .off_i  (rv_off_i),
    .data_i (rv_data_i),
    .done_o (fill_done),
    .line_o (fill_line)
  );

  wmiss_merge #(.WORDS(WORDS), .DW(DW)) merge_i (
    .line_i (fill_line),
    .off_i  (fb_off),
    .data_i (fb_data_q),
    .be_i   (fb_be_q),
    .line_o (inst_line)
  );

  wmiss_half_sel #(.WORDS(WORDS), .DW(DW)) half_sel_i (
    .half_i (ev_half),
    .line_i (vic_data_i),
    .data_o (ev_data)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (acc_alloc) state_d = S_REQ;
      S_REQ:   state_d = S_FILL;
      S_FILL:  if (fill_beat && fill_done) state_d = S_EV_LO;
      S_EV_LO: if (!ev_need || !wb_full_i) state_d = S_EV_HI;
      S_EV_HI: if (!ev_need || !wb_full_i) state_d = S_INST;
      S_INST:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      fb_addr_q <= '0;
      fb_data_q <= '0;
      fb_be_q   <= '0;
      fb_wt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (acc_alloc) begin
        fb_addr_q <= st_addr_i;
        fb_data_q <= st_data_i;
        fb_be_q   <= st_be_i;
        fb_wt_q   <= st_wt_i;
      end
    end
  end

  assign rd_req_o  = (state_q == S_REQ);
  assign rd_addr_o = {fb_addr_q[AW-1:OFFB], {OFFB{1'b0}}};

  always_comb begin
    wb_push_o  = 1'b0;
    wb_burst_o = 1'b0;
    wb_addr_o  = '0;
    wb_data_o  = '0;
    wb_be_o    = '0;
    cw_en_o    = 1'b0;
    cw_fill_o  = 1'b0;
    cw_line_o  = '0;
    cw_data_o  = '0;
    cw_be_o    = '0;
    cw_dirty_o = 2'b00;
    if (acc && needs_push) begin
      wb_push_o = 1'b1;
      wb_addr_o = {st_addr_i[AW-1:BOB], {BOB{1'b0}}};
      wb_data_o = HDW'(st_data_i);
      wb_be_o   = st_be_i;
    end
    if (acc && st_hit_i) begin
      cw_en_o    = 1'b1;
      cw_line_o  = st_addr_i[AW-1:OFFB];
      cw_data_o  = {WORDS{st_data_i}};
      cw_be_o    = LB'(st_be_i) << (st_off * BB);
      cw_dirty_o = st_wt_i ? 2'b00 : (2'b01 << st_off[OW-1]);
    end
    if (in_ev && ev_need && !wb_full_i) begin
      wb_push_o  = 1'b1;
      wb_burst_o = 1'b1;
      wb_addr_o  = {vic_line_i, ev_half, {(OFFB-1){1'b0}}};
      wb_data_o  = ev_data;
      wb_be_o    = '1;
    end
    if (state_q == S_INST) begin
      cw_en_o    = 1'b1;
      cw_fill_o  = 1'b1;
      cw_line_o  = fb_addr_q[AW-1:OFFB];
      cw_data_o  = inst_line;
      cw_be_o    = '1;
      cw_dirty_o = fb_wt_q ? 2'b00 : (2'b01 << fb_off[OW-1]);
    end
  end
endmodule

// File: rtl/wmiss_alloc_ctrl_chk.sv
module wmiss_alloc_ctrl_chk #(
  parameter int AW    = 32,
  parameter int WORDS = 8,
  parameter int DW    = 32,
  localparam int BB   = DW / 8,
  localparam int OFFB = $clog2(WORDS) + $clog2(BB)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          st_ready_o,
  input logic          rd_req_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          wb_push_o,
  input logic          wb_full_i,
  input logic          wb_burst_o,
  input logic [AW-1:0] wb_addr_o,
  input logic [BB-1:0] wb_be_o,
  input logic          cw_en_o,
  input logic          cw_fill_o,
  input logic [1:0]    cw_dirty_o
);
  assert_push_room_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_push_o |-> !wb_full_i);

  assert_rdreq_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);

  assert_rdreq_align_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> (rd_addr_o[OFFB-1:0] == '0));

  assert_busy_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o || cw_fill_o) |-> !st_ready_o);

  assert_burst_shape_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_push_o && wb_burst_o) |-> (&wb_be_o && wb_addr_o[OFFB-2:0] == '0));

  assert_hit_dirty_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cw_en_o && !cw_fill_o) |-> $onehot0(cw_dirty_o));

  assert_wt_clean_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cw_en_o && !cw_fill_o && wb_push_o) |-> (cw_dirty_o == 2'b00));
endmodule

bind wmiss_alloc_ctrl wmiss_alloc_ctrl_chk #(.AW(AW), .WORDS(WORDS), .DW(DW)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .st_ready_o (st_ready_o),
  .rd_req_o   (rd_req_o),
  .rd_addr_o  (rd_addr_o),
  .wb_push_o  (wb_push_o),
  .wb_full_i  (wb_full_i),
  .wb_burst_o (wb_burst_o),
  .wb_addr_o  (wb_addr_o),
  .wb_be_o    (wb_be_o),
  .cw_en_o    (cw_en_o),
  .cw_fill_o  (cw_fill_o),
  .cw_dirty_o (cw_dirty_o)
);

// File: tb/wmiss_alloc_ctrl_tb_top.sv
module wmiss_alloc_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic st_valid = 0, st_hit = 0, st_wt = 0, st_alloc = 0;
  logic [31:0] st_addr = 0, st_data = 0;
  logic [3:0]  st_be = 0;
  logic rv_valid = 0;
  logic [2:0] rv_off = 0;
  logic [31:0] rv_data = 0;
  logic vic_valid = 0;
  logic [1:0] vic_dirty = 0;
  logic [26:0] vic_line = 0;
  logic [255:0] vic_data = 0;
  logic wb_full = 0;
  logic st_ready, rd_req, wb_push, wb_burst, cw_en, cw_fill;
  logic [31:0] rd_addr, wb_addr;
  logic [127:0] wb_data;
  logic [3:0] wb_be;
  logic [26:0] cw_line;
  logic [255:0] cw_data;
  logic [31:0] cw_be;
  logic [1:0] cw_dirty;

  wmiss_alloc_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .st_valid_i(st_valid), .st_ready_o(st_ready), .st_addr_i(st_addr),
    .st_data_i(st_data), .st_be_i(st_be), .st_hit_i(st_hit), .st_wt_i(st_wt),
    .st_alloc_i(st_alloc), .rd_req_o(rd_req), .rd_addr_o(rd_addr),
    .rv_valid_i(rv_valid), .rv_off_i(rv_off), .rv_data_i(rv_data),
    .vic_valid_i(vic_valid), .vic_dirty_i(vic_dirty), .vic_line_i(vic_line),
    .vic_data_i(vic_data), .wb_push_o(wb_push), .wb_full_i(wb_full),
    .wb_burst_o(wb_burst), .wb_addr_o(wb_addr), .wb_data_o(wb_data),
    .wb_be_o(wb_be), .cw_en_o(cw_en), .cw_fill_o(cw_fill), .cw_line_o(cw_line),
    .cw_data_o(cw_data), .cw_be_o(cw_be), .cw_dirty_o(cw_dirty)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  typedef struct packed {
    logic hit, wt, alloc, full;
    logic [31:0] addr, data;
    logic [3:0] be;
    logic e_rdy, e_cw, e_push;
    logic [1:0] e_dirty;
    logic [31:0] e_be;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b1, 1'b0, 1'b0, 1'b0, 32'h1000_0004, 32'hA5A5_0001, 4'hF, 1'b1, 1'b1, 1'b0, 2'b01, 32'h0000_00F0},
    '{1'b1, 1'b0, 1'b0, 1'b0, 32'h1000_0014, 32'hA5A5_0002, 4'h3, 1'b1, 1'b1, 1'b0, 2'b10, 32'h0030_0000},
    '{1'b1, 1'b1, 1'b0, 1'b0, 32'h1000_0008, 32'hA5A5_0003, 4'hC, 1'b1, 1'b1, 1'b1, 2'b00, 32'h0000_0C00},
    '{1'b1, 1'b1, 1'b0, 1'b1, 32'h1000_0008, 32'hA5A5_0004, 4'hF, 1'b0, 1'b0, 1'b0, 2'b00, 32'h0},
    '{1'b0, 1'b0, 1'b0, 1'b0, 32'h1000_101E, 32'hA5A5_0005, 4'h1, 1'b1, 1'b0, 1'b1, 2'b00, 32'h0},
    '{1'b0, 1'b0, 1'b0, 1'b1, 32'h1000_101C, 32'hA5A5_0006, 4'hF, 1'b0, 1'b0, 1'b0, 2'b00, 32'h0},
    '{1'b1, 1'b0, 1'b0, 1'b1, 32'h1000_0018, 32'hA5A5_0007, 4'hF, 1'b1, 1'b1, 1'b0, 2'b10, 32'h0F00_0000}
  };

  function automatic logic [31:0] fetched(input int w);
    return 32'h1111_0000 + 32'(w) * 32'h101;
  endfunction

  task automatic do_alloc(input logic [31:0] addr, input logic [31:0] data, input logic [3:0] be,
                          input logic wt, input logic perm, input logic vv, input logic [1:0] vd,
                          input int hold);
    logic [255:0] exp_line;
    int np, exp_np;
    bit done;
    int off;
    off = int'(addr[4:2]);
    vic_valid = vv; vic_dirty = vd; vic_line = 27'h180_0000;
    for (int w = 0; w < 8; w++) vic_data[w*32 +: 32] = 32'hB000_0000 + 32'(w);
    st_valid = 1; st_hit = 0; st_alloc = 1; st_wt = wt;
    st_addr = addr; st_data = data; st_be = be;
    #8;
    chk("R9 accept when idle", st_ready, 1);
    chk("R8 wt allocate push at accept", wb_push, wt);
    if (wt) chk("R8 wt allocate push data", wb_data[31:0], data);
    chk("R4 no read at accept", rd_req, 0);
    step();
    st_valid = 0;
    #8;
    chk("R4 read request", rd_req, 1);
    chk("R4 read address", rd_addr, addr & ~32'h1F);
    chk("R9 busy stalls", st_ready, 0);
    step();
    for (int i = 0; i < 8; i++) begin
      int o;
      o = perm ? (i * 5 + 3) % 8 : i;
      rv_valid = 1; rv_off = 3'(o); rv_data = fetched(o);
      #8;
      chk("R5 no install before all words", cw_en, 0);
      chk("R4 single read", rd_req, 0);
      step();
    end
    rv_valid = 0;
    wb_full = (hold > 0);
    for (int h = 0; h < hold; h++) begin
      #8;
      chk("R7 no push while full", wb_push, 0);
      chk("R7 no install while stalled", cw_en, 0);
      step();
    end
    wb_full = 0;
    exp_np = vv ? $countones(vd) : 0;
    np = 0; done = 0;
    for (int k = 0; k < 4 && !done; k++) begin
      #8;
      if (wb_push) begin
        logic hsel;
        hsel = (np == 0 && vd[0]) ? 1'b0 : 1'b1;
        chk("R6 burst flag", wb_burst, 1);
        chk("R6 burst address", wb_addr, {vic_line, hsel, 4'h0});
        chk("R6 burst data", wb_data, vic_data[hsel*128 +: 128]);
        np++;
      end
      if (cw_en) begin
        exp_line = 0;
        for (int w = 0; w < 8; w++) exp_line[w*32 +: 32] = fetched(w);
        for (int b = 0; b < 4; b++)
          if (be[b]) exp_line[off*32 + b*8 +: 8] = data[b*8 +: 8];
        chk("R8 install full line", cw_fill, 1);
        chk("R8 install line address", cw_line, addr[31:5]);
        chk("R8 install merged data", cw_data, exp_line);
        chk("R8 install dirty", cw_dirty, wt ? 2'b00 : (addr[4] ? 2'b10 : 2'b01));
        done = 1;
      end
      step();
    end
    chk("R6 burst count", np, exp_np);
    chk("R8 install happened", done, 1);
    #8;
    chk("R9 ready after install", st_ready, 1);
    step();
  endtask

  initial begin
    #4000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #5;
    chk("R10 ready in reset", st_ready, 1);
    chk("R10 no read in reset", rd_req, 0);
    chk("R10 no push in reset", wb_push, 0);
    chk("R10 no cache write in reset", cw_en, 0);
    #30; rst_n = 1;
    step();

    for (int i = 0; i < 7; i++) begin
      vec_t v;
      string tag;
      v = VECS[i];
      tag = v.full ? "R7" : (v.hit ? (v.wt ? "R2" : "R1") : "R3");
      st_valid = 1; st_hit = v.hit; st_wt = v.wt; st_alloc = v.alloc;
      st_addr = v.addr; st_data = v.data; st_be = v.be; wb_full = v.full;
      #8;
      chk({tag, " ready"}, st_ready, v.e_rdy);
      chk({tag, " cache write"}, cw_en, v.e_cw);
      chk({tag, " push"}, wb_push, v.e_push);
      chk({tag, " no line read"}, rd_req, 0);
      if (v.e_cw) begin
        chk({tag, " dirty"}, cw_dirty, v.e_dirty);
        chk({tag, " byte enables"}, cw_be, v.e_be);
        chk({tag, " word data"}, cw_data[int'(v.addr[4:2])*32 +: 32], v.data);
      end
      if (v.e_push) begin
        chk({tag, " push address"}, wb_addr, v.addr & ~32'h3);
        chk({tag, " push enables"}, wb_be, v.be);
        chk({tag, " push data"}, wb_data, {96'h0, v.data});
        chk({tag, " single push"}, wb_burst, 0);
      end
      step();
      st_valid = 0; wb_full = 0;
      step();
    end

    do_alloc(32'h2000_0044, 32'hDEAD_BEEF, 4'h6, 1'b0, 1'b1, 1'b1, 2'b11, 2);
    do_alloc(32'h2000_0078, 32'hCAFE_F00D, 4'hF, 1'b1, 1'b0, 1'b1, 2'b10, 0);
    do_alloc(32'h2000_0100, 32'h1234_5678, 4'h8, 1'b0, 1'b1, 1'b0, 2'b11, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule